// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns eight external interrupt pins into per-pin interrupt requests. Each pin has its own 2-bit sense selector. The selector picks one of four detection modes: level-low, any transition, falling transition or rising transition. Every pin input first passes through a synchronizer clocked by the system clock. Edges are then found by comparing the last two synchronized samples, so a pin state that lasts longer than one clock period is always seen.

In the three edge modes, a detected edge sets a per-pin pending flag. The flag is set whether or not the pin is masked. Software clears it by writing a 1 to its bit, or the handler clears it by pulsing that pin's acknowledge line. In level mode no flag is latched. The request stays high for as long as the synchronized pin stays low. A request leaves the block only when the global enable and that pin's mask bit are both set.

The block reads only the pin value. Logic that drives a pin can therefore raise an interrupt on that pin. Software should clear a pin's mask bit before it changes that pin's sense field, because the change itself can look like an edge.

Top module: `eirq_sense_ctrl`

## Requirements
- R1: While reset is held and straight after it is released, with the pins idle high, `flag_o` and `irq_o` are all zero.
- R2: With sense code 00 (level-low), the pin's request is high while its synchronized value is 0. The request rises two clock edges after the pin goes low and drops two edges after it returns high. It stays high for the whole time the pin is held low, and the pin's `flag_o` bit is never set by the pin in this mode.
- R3: With sense code 01 (any change), both a 1-to-0 and a 0-to-1 transition of the pin set its flag.
- R4: With sense code 10 (falling), only a 1-to-0 transition sets the flag; a rising transition leaves it unchanged.
- R5: With sense code 11 (rising), only a 0-to-1 transition sets the flag; a falling transition leaves it unchanged.
- R6: A pin value first sampled at clock edge k sets the flag after edge k+2 and not earlier. The pin passes through two synchronizer flops, then one compare stage.
- R7: Flags are set regardless of `mask_i` and `gie_i`. Bit i of `irq_o` is high only when `gie_i` is 1 and `mask_i[i]` is 1. The output follows changes of either input in the same cycle.
- R8: A flag is cleared on a clock edge where `ack_i[i]` is 1, or where `clr_wr_i` is 1 and `clr_data_i[i]` is 1. A flag falls for no other reason.
- R9: If a new edge is detected on the same edge as a clear, the flag ends up set.
- R10: Pin i uses field `sense_i[2i+1:2i]` and bit i of every other vector. Clearing or setting one pin leaves the other flags untouched, and 0 bits in `clr_data_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Raw external interrupt pins |
| sense_i | input | 16 | Per-pin 2-bit sense selector, pin i in bits [2i+1:2i] |
| mask_i | input | 8 | Per-pin request enable |
| gie_i | input | 1 | Global interrupt enable |
| clr_wr_i | input | 1 | Write strobe for write-1-to-clear of the flags |
| clr_data_i | input | 8 | Write-1-to-clear data, one bit per pin |
| ack_i | input | 8 | Per-pin handler acknowledge, clears that flag |
| irq_o | output | 8 | Per-pin interrupt requests |
| flag_o | output | 8 | Per-pin pending edge flags |

## Verification
The assertions check four things on every cycle. Requests are gated by the global enable and the mask. A flag never rises in level mode. A flag falls only under a clear or an acknowledge. Every flag rise follows a real pin transition at the synchronizer depth. The bench scenarios cover what the properties cannot show. These are the exact cycle a flag appears, the mode-by-mode choice of which transitions count, a level request held over many cycles, a new edge winning over a clear on the same edge, and the isolation of one pin's clear from the others.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   WIDTH    = 8,
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {WIDTH{IDLE_LVL}};
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_edge_cell.sv
module eirq_edge_cell
  import eirq_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   smp_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   level_o
);
  logic prev_q, flag_q, hit;
  logic rise, fall;

  assign rise = smp_i & ~prev_q;
  assign fall = ~smp_i & prev_q;

  always_comb begin
    unique case (sense_i)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= IDLE_LVL;
      flag_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
      // a fresh edge outranks a clear in the same cycle
      if (hit) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign level_o = (sense_i == SENSE_LOW) & ~smp_i;
endmodule

// File: rtl/eirq_sense_ctrl.sv
module eirq_sense_ctrl
  import eirq_pkg::*;
#(
  parameter int   NUM_PINS    = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LVL    = 1'b1,
  localparam int  SENSE_W     = 2 * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [SENSE_W-1:0]  sense_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic                gie_i,
  input  logic                clr_wr_i,
  input  logic [NUM_PINS-1:0] clr_data_i,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [NUM_PINS-1:0] irq_o,
  output logic [NUM_PINS-1:0] flag_o
);
  logic [NUM_PINS-1:0] smp, level, clr;

  eirq_sync #(
    .WIDTH   (NUM_PINS),
    .STAGES  (SYNC_STAGES),
    .IDLE_LVL(IDLE_LVL)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (smp)
  );

  assign clr = ack_i | ({NUM_PINS{clr_wr_i}} & clr_data_i);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    eirq_edge_cell #(
      .IDLE_LVL(IDLE_LVL)
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp[i]),
      .sense_i(sense_e'(sense_i[2*i +: 2])),
      .clr_i  (clr[i]),
      .flag_o (flag_o[i]),
      .level_o(level[i])
    );
  end

  assign irq_o = {NUM_PINS{gie_i}} & mask_i & (flag_o | level);
endmodule

// File: rtl/eirq_sense_chk.sv
module eirq_sense_chk #(
  parameter int  NUM_PINS    = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int SENSE_W     = 2 * NUM_PINS,
  localparam int HIST        = SYNC_STAGES + 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [SENSE_W-1:0]  sense_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic                gie_i,
  input logic                clr_wr_i,
  input logic [NUM_PINS-1:0] clr_data_i,
  input logic [NUM_PINS-1:0] ack_i,
  input logic [NUM_PINS-1:0] irq_o,
  input logic [NUM_PINS-1:0] flag_o
);
  logic [NUM_PINS-1:0] hist_q [HIST];
  logic [3:0]          since_rst;
  logic                settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 4'hf) since_rst <= since_rst + 4'd1;
  end
  assign settled = since_rst >= 4'(SYNC_STAGES + 3);

  for (genvar h = 0; h < HIST; h++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[h] <= '0;
      else if (h == 0) hist_q[h] <= pin_i;
      else hist_q[h] <= hist_q[(h == 0) ? 0 : h-1];
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_prop
    assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> (gie_i && mask_i[i]));

    assert_level_noflag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> ($past(sense_i[2*i +: 2]) != 2'b00));

    assert_flag_clr_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[i]) |-> $past(ack_i[i] || (clr_wr_i && clr_data_i[i])));

    // hist_q[n] holds pin_i sampled n+1 edges ago
    assert_flag_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && $rose(flag_o[i])) |->
        (hist_q[SYNC_STAGES][i] != hist_q[SYNC_STAGES+1][i]));
  end
endmodule

bind eirq_sense_ctrl eirq_sense_chk #(
  .NUM_PINS   (NUM_PINS),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pin_i     (pin_i),
  .sense_i   (sense_i),
  .mask_i    (mask_i),
  .gie_i     (gie_i),
  .clr_wr_i  (clr_wr_i),
  .clr_data_i(clr_data_i),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .flag_o    (flag_o)
);

// File: tb/eirq_sense_ctrl_tb.sv
module eirq_sense_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin = 8'hff;
  // p7..p0 = fall, any, rise, level, fall, any, fall, rise
  logic [15:0] sense = 16'h9C9B;
  logic [7:0]  mask = 8'hF7;
  logic        gie = 1'b1;
  logic        clr_wr = 1'b0;
  logic [7:0]  clr_data = 8'h00;
  logic [7:0]  ack = 8'h00;
  logic [7:0]  irq, flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0] ef;
    logic [7:0] ei;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eirq_sense_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .sense_i(sense),
    .mask_i(mask), .gie_i(gie), .clr_wr_i(clr_wr), .clr_data_i(clr_data),
    .ack_i(ack), .irq_o(irq), .flag_o(flag)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [7:0] ef, input logic [7:0] ei);
    exp_q.push_back('{ef: ef, ei: ei});
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
  endtask

  // monitor: pops expected items and compares them to the ports
  initial begin
    forever begin
      exp_t  it;
      string tg;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (flag !== it.ef || irq !== it.ei) begin
        failures++;
        $display("FAIL %s flag=%h irq=%h expected flag=%h irq=%h",
                 tg, flag, irq, it.ef, it.ei);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_out("R1 in reset", 8'h00, 8'h00);
    rst_n = 1'b1;
    step(3);
    expect_out("R1 after reset", 8'h00, 8'h00);

    pin[0] = 1'b0; step(4);
    expect_out("R5 fall ignored in rise mode", 8'h00, 8'h00);
    pin[0] = 1'b1; step(2);
    expect_out("R6 not yet after two edges", 8'h00, 8'h00);
    step(1);
    expect_out("R5 R6 rise flag", 8'h01, 8'h01);
    clr_wr = 1'b1; clr_data = 8'h01; step(1);
    clr_wr = 1'b0; clr_data = 8'h00;
    expect_out("R8 write-one clear", 8'h00, 8'h00);

    pin[1] = 1'b0; step(3);
    expect_out("R4 fall flag", 8'h02, 8'h02);
    ack = 8'h02; step(1); ack = 8'h00;
    expect_out("R8 ack clear", 8'h00, 8'h00);
    pin[1] = 1'b1; step(4);
    expect_out("R4 rise ignored", 8'h00, 8'h00);

    pin[2] = 1'b0; step(3);
    expect_out("R3 any-change fall", 8'h04, 8'h04);
    ack = 8'h04; step(1); ack = 8'h00;
    expect_out("R3 cleared", 8'h00, 8'h00);
    pin[2] = 1'b1; step(3);
    expect_out("R3 any-change rise", 8'h04, 8'h04);
    clr_wr = 1'b1; clr_data = 8'h04; step(1);
    clr_wr = 1'b0; clr_data = 8'h00;

    pin[3] = 1'b0; step(3);
    expect_out("R7 masked flag sets no irq", 8'h08, 8'h00);
    mask = 8'hFF; #1;
    expect_out("R7 unmask gives irq", 8'h08, 8'h08);
    gie = 1'b0; #1;
    expect_out("R7 global disable", 8'h08, 8'h00);
    gie = 1'b1; step(1);

    pin[4] = 1'b0; step(1);
    expect_out("R2 level after one edge", 8'h08, 8'h08);
    step(1);
    expect_out("R2 level request", 8'h08, 8'h18);
    step(5);
    expect_out("R2 level held no flag", 8'h08, 8'h18);
    pin[4] = 1'b1; step(2);
    expect_out("R2 level released", 8'h08, 8'h08);

    pin[5] = 1'b0; step(4);
    expect_out("R5 pin5 fall ignored", 8'h08, 8'h08);
    pin[5] = 1'b1; step(2);
    ack = 8'h20; step(1); ack = 8'h00;
    expect_out("R9 set beats clear", 8'h28, 8'h28);

    clr_wr = 1'b1; clr_data = 8'h08; step(1);
    clr_wr = 1'b0; clr_data = 8'h00;
    expect_out("R10 clear one bit only", 8'h20, 8'h20);
    pin[7] = 1'b0; pin[6] = 1'b0; step(3);
    expect_out("R10 two pins together", 8'hE0, 8'hE0);
    clr_wr = 1'b1; clr_data = 8'hE0; step(1);
    clr_wr = 1'b0; clr_data = 8'h00;
    expect_out("R8 R10 multi clear", 8'h00, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule